// File: doc/BRIEF.md
# Vectored Interrupt Controller with Word Register Port

The controller collects up to 32 interrupt request lines into a sticky status word. Each line's sensitivity is fixed when the block is built: a line is either level-sensitive, which sets its status bit on every cycle the line is high, or edge-sensitive, which sets its bit only on a low-to-high transition. Status bits are masked by an enable word to give the pending set. The lowest-numbered pending line is reported as a vector, and a single request line goes to the processor. All request lines are assumed to be synchronous to the controller clock.

Software works through a simple word-addressed read/write port. It acknowledges lines by writing ones to an acknowledge word. It changes enables atomically through set and clear words, or it replaces the enable word outright. A two-bit master word selects one of four operating modes. The modes are handled by a small state machine:

- **HALT** (code 00): no capture and no output. This is the reset state.
- **SIGNAL** (01): the output is live but there is no capture. Software can raise interrupts itself by writing the status word.
- **CAPTURE** (10): lines are captured but the output is held low.
- **RUN** (11): capture and output are both live.

Every transition is the same kind of event: a write to the master word moves the machine from any state to the state coded by write bits 1:0. Reset moves it to HALT.

Top module: `vec_intc`

## Requirements
- R1: After reset, the status, enable and master words read 0. The vector word reads 0xFFFFFFFF and the processor request output is low.
- R2: Only bits 1:0 of a master word write are kept. Bits 31:2 of the master word always read 0.
- R3: While capture is on (master bit 1), a level-sensitive line (build mask bit 0) that is high at a clock edge sets its status bit. The bit stays set after the line falls.
- R4: While capture is on, an edge-sensitive line (build mask bit 1) sets its status bit only on a 0-to-1 change from the previous cycle's sample. Holding the line high does not set the bit again after an acknowledge. The bit stays set after the line falls.
- R5: The pending word (word offset 1) reads status AND enable.
- R6: The vector word (offset 6) reads the index of the lowest-numbered pending bit. It reads 0xFFFFFFFF when nothing is pending.
- R7: The request output is high exactly when master bit 0 is set and at least one bit is pending.
- R8: Writing the acknowledge word (offset 3) clears each status bit written as 1. Capture in the same cycle wins, so a level line that is still high stays set.
- R9: Writing the enable word (offset 2) replaces it. Writing offset 4 ORs the data into enable. Writing offset 5 clears each enable bit written as 1.
- R10: A write to the status word (offset 0) loads it only while capture is off. While capture is on, the write has no effect.
- R11: Reads of offsets 3, 4, 5 and of unmapped offsets 8 to 15 return 0. Writes to unmapped offsets change nothing.
- R12: While capture is off, line activity leaves the status word unchanged.
- R13: The master word (offset 7) reads back the current mode code: HALT 00, SIGNAL 01, CAPTURE 10, RUN 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | 32 | Interrupt request lines, already synchronous |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 4 | Word offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the word at bus_addr (combinational) |
| cpu_irq | output | 1 | Request output to the processor |

## Verification
Assertions check several properties on every cycle:
- the request output is never high while the output mode is off, and never high with an empty pending set;
- the vector always points at a pending bit with no lower pending bit, or reads all ones when nothing is pending;
- a high level line always shows in status one cycle later;
- status never loses a bit while capture is on unless an acknowledge is written, and stays fixed while capture is off and the port is idle.

Only the bench scenarios can show the rest. These cover:
- that a held edge line does not set its bit again after an acknowledge;
- that a status write is ignored once capture starts;
- that priority moves to the next line after an acknowledge;
- that the atomic set and clear writes combine correctly.

// File: rtl/vec_intc_pkg.sv
package vec_intc_pkg;

    typedef enum logic [1:0] {
        MODE_HALT    = 2'b00,
        MODE_SIGNAL  = 2'b01,
        MODE_CAPTURE = 2'b10,
        MODE_RUN     = 2'b11
    } intc_mode_e;

    localparam int unsigned OFS_STATUS  = 0;
    localparam int unsigned OFS_PENDING = 1;
    localparam int unsigned OFS_ENABLE  = 2;
    localparam int unsigned OFS_ACK     = 3;
    localparam int unsigned OFS_SETEN   = 4;
    localparam int unsigned OFS_CLREN   = 5;
    localparam int unsigned OFS_VECTOR  = 6;
    localparam int unsigned OFS_MASTER  = 7;

endpackage

// File: rtl/vec_intc_mode.sv
module vec_intc_mode
    import vec_intc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [1:0] code,
    output intc_mode_e mode,
    output logic       out_en,
    output logic       cap_en
);

    intc_mode_e mode_q;
    intc_mode_e mode_d;

    always_comb begin
        mode_d = mode_q;
        if (load) begin
            mode_d = intc_mode_e'(code);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_HALT;
        end else begin
            mode_q <= mode_d;
        end
    end

    always_comb begin
        out_en = 1'b0;
        cap_en = 1'b0;
        unique case (mode_q)
            MODE_HALT: begin
                out_en = 1'b0;
                cap_en = 1'b0;
            end
            MODE_SIGNAL: begin
                out_en = 1'b1;
                cap_en = 1'b0;
            end
            MODE_CAPTURE: begin
                out_en = 1'b0;
                cap_en = 1'b1;
            end
            MODE_RUN: begin
                out_en = 1'b1;
                cap_en = 1'b1;
            end
            default: begin
                out_en = 1'b0;
                cap_en = 1'b0;
            end
        endcase
    end

    assign mode = mode_q;

    // R13: a master write selects the coded state on the next cycle
    assert_mode_load_R13: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (mode_q == intc_mode_e'($past(code))));

    // R13: without a master write the mode holds
    assert_mode_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(mode_q));

endmodule

// File: rtl/vec_intc_capture.sv
module vec_intc_capture #(
    parameter int unsigned        N_SRC     = 32,
    parameter logic [N_SRC-1:0]   EDGE_MASK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src,
    input  logic             cap_en,
    output logic [N_SRC-1:0] hit
);

    localparam logic [N_SRC-1:0] LEVEL_MASK = ~EDGE_MASK;

    logic [N_SRC-1:0] src_q;
    logic [N_SRC-1:0] rise;
    logic [N_SRC-1:0] raw_hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
        end else begin
            src_q <= src;
        end
    end

    always_comb begin
        rise    = src & ~src_q;
        raw_hit = (rise & EDGE_MASK) | (src & LEVEL_MASK);
        hit     = cap_en ? raw_hit : '0;
    end

    // R12: nothing is captured while capture is off
    assert_no_hit_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |-> (hit == '0));

    // R4: an edge line held high from the previous cycle never reports a hit
    assert_edge_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit & EDGE_MASK & src_q) == '0);

endmodule

// File: rtl/vec_intc_prio.sv
module vec_intc_prio #(
    parameter int unsigned N_SRC = 32,
    localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] pending,
    output logic [IDX_W-1:0] idx,
    output logic             any
);

    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pending[i]) begin
                idx = IDX_W'(i);
                any = 1'b1;
            end
        end
    end

endmodule

// File: rtl/vec_intc.sv
module vec_intc
    import vec_intc_pkg::*;
#(
    parameter int unsigned        N_SRC     = 32,
    parameter int unsigned        DATA_W    = 32,
    parameter int unsigned        ADDR_W    = 4,
    parameter logic [N_SRC-1:0]   EDGE_MASK = 32'hFFFF_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  irq_src,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              cpu_irq
);

    localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
    localparam logic [N_SRC-1:0] LEVEL_MASK = ~EDGE_MASK;

    intc_mode_e        mode;
    logic              out_en;
    logic              cap_en;
    logic [N_SRC-1:0]  hit;
    logic [N_SRC-1:0]  status_q, status_d;
    logic [N_SRC-1:0]  enable_q, enable_d;
    logic [N_SRC-1:0]  pending;
    logic [N_SRC-1:0]  wsrc;
    logic [IDX_W-1:0]  vec_idx;
    logic              any_pend;
    logic [DATA_W-1:0] vector_word;
    logic wr_status, wr_enable, wr_ack, wr_seten, wr_clren, wr_master;

    assign wsrc      = bus_wdata[N_SRC-1:0];
    assign wr_status = bus_wr && (bus_addr == ADDR_W'(OFS_STATUS));
    assign wr_enable = bus_wr && (bus_addr == ADDR_W'(OFS_ENABLE));
    assign wr_ack    = bus_wr && (bus_addr == ADDR_W'(OFS_ACK));
    assign wr_seten  = bus_wr && (bus_addr == ADDR_W'(OFS_SETEN));
    assign wr_clren  = bus_wr && (bus_addr == ADDR_W'(OFS_CLREN));
    assign wr_master = bus_wr && (bus_addr == ADDR_W'(OFS_MASTER));

    vec_intc_mode u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (wr_master),
        .code   (bus_wdata[1:0]),
        .mode   (mode),
        .out_en (out_en),
        .cap_en (cap_en)
    );

    vec_intc_capture #(
        .N_SRC     (N_SRC),
        .EDGE_MASK (EDGE_MASK)
    ) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .src    (irq_src),
        .cap_en (cap_en),
        .hit    (hit)
    );

    // Status: software write or acknowledge first, capture ORed last
    always_comb begin
        status_d = status_q;
        if (wr_ack) begin
            status_d = status_d & ~wsrc;
        end
        if (wr_status && !cap_en) begin
            status_d = wsrc;
        end
        status_d = status_d | hit;
    end

    always_comb begin
        enable_d = enable_q;
        if (wr_enable) begin
            enable_d = wsrc;
        end
        if (wr_seten) begin
            enable_d = enable_d | wsrc;
        end
        if (wr_clren) begin
            enable_d = enable_d & ~wsrc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            enable_q <= '0;
        end else begin
            status_q <= status_d;
            enable_q <= enable_d;
        end
    end

    assign pending = status_q & enable_q;

    vec_intc_prio #(
        .N_SRC (N_SRC)
    ) u_prio (
        .pending (pending),
        .idx     (vec_idx),
        .any     (any_pend)
    );

    assign vector_word = any_pend ? DATA_W'(vec_idx) : '1;
    assign cpu_irq     = out_en && any_pend;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_STATUS):  bus_rdata = DATA_W'(status_q);
            ADDR_W'(OFS_PENDING): bus_rdata = DATA_W'(pending);
            ADDR_W'(OFS_ENABLE):  bus_rdata = DATA_W'(enable_q);
            ADDR_W'(OFS_VECTOR):  bus_rdata = vector_word;
            ADDR_W'(OFS_MASTER):  bus_rdata = DATA_W'(mode);
            default:              bus_rdata = '0;
        endcase
    end

    // R1: leaving reset the output is quiet
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> !cpu_irq);

    // R7: request never raised with the output mode off or nothing pending
    assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> (out_en && (pending != '0)));

    // R6: vector points at a pending bit with nothing lower pending
    assert_vec_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pending != '0) |-> pending[vec_idx]);
    assert_vec_lowest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pending != '0) |-> ((pending & ((N_SRC'(1) << vec_idx) - N_SRC'(1))) == '0));
    assert_vec_none_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFS_VECTOR) && pending == '0) |-> (bus_rdata == '1));

    // R3: a high level line is visible in status one cycle later
    assert_level_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && ((irq_src & LEVEL_MASK) != '0))
        |=> ((status_q & $past(irq_src & LEVEL_MASK)) == $past(irq_src & LEVEL_MASK)));

    // R10: with capture on, only an acknowledge can remove status bits
    assert_status_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && !wr_ack) |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R12: capture off and port idle leaves status untouched
    assert_status_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_en && !bus_wr) |=> $stable(status_q));

    // R8: acknowledge with capture off clears the written ones
    assert_ack_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ack && !cap_en) |=> ((status_q & $past(wsrc)) == '0));

    // R2: upper master bits read zero
    assert_master_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFS_MASTER)) |-> (bus_rdata[DATA_W-1:2] == '0));

    // R11: write-only and unmapped offsets read zero
    assert_wo_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFS_ACK) || bus_addr == ADDR_W'(OFS_SETEN) ||
         bus_addr == ADDR_W'(OFS_CLREN) || bus_addr > ADDR_W'(OFS_MASTER))
        |-> (bus_rdata == '0));

endmodule

// File: tb/test_vec_intc.sv
module test_vec_intc;

    localparam int unsigned N  = 32;
    localparam int unsigned DW = 32;
    localparam int unsigned AW = 4;
    localparam logic [31:0] EDGE = 32'hFFFF_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_src = '0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          cpu_irq;

    vec_intc #(
        .N_SRC     (N),
        .DATA_W    (DW),
        .ADDR_W    (AW),
        .EDGE_MASK (EDGE)
    ) i_vec_intc (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_src   (irq_src),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cpu_irq   (cpu_irq)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Behavioural reference model
    logic [31:0] m_status = '0;
    logic [31:0] m_enable = '0;
    logic [31:0] m_prev   = '0;
    logic [1:0]  m_master = '0;
    bit          m_cap;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_status = '0;
            m_enable = '0;
            m_prev   = '0;
            m_master = '0;
        end else begin
            m_cap = m_master[1];
            if (bus_wr) begin
                case (bus_addr)
                    4'd0: if (!m_cap) m_status = bus_wdata;
                    4'd2: m_enable = bus_wdata;
                    4'd3: m_status = m_status & ~bus_wdata;
                    4'd4: m_enable = m_enable | bus_wdata;
                    4'd5: m_enable = m_enable & ~bus_wdata;
                    4'd7: m_master = bus_wdata[1:0];
                    default: ;
                endcase
            end
            if (m_cap) begin
                m_status = m_status | (irq_src & ~EDGE) | (irq_src & ~m_prev & EDGE);
            end
            m_prev = irq_src;
        end
    end

    function automatic logic [31:0] m_read(input logic [3:0] a);
        logic [31:0] p;
        logic [31:0] v;
        p = m_status & m_enable;
        v = 32'hFFFF_FFFF;
        for (int i = 31; i >= 0; i--) begin
            if (p[i]) v = i;
        end
        case (a)
            4'd0: return m_status;
            4'd1: return p;
            4'd2: return m_enable;
            4'd6: return v;
            4'd7: return {30'd0, m_master};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R5/R6 model read", bus_rdata, m_read(bus_addr));
            check("R7 model irq", {31'd0, cpu_irq},
                  {31'd0, (m_master[0] && ((m_status & m_enable) != 0))});
        end
    end

    // Tasks start and end one time unit after a rising edge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic expect_rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        @(negedge clk);
        check(tag, bus_rdata, exp);
        @(posedge clk); #1;
    endtask

    task automatic expect_irq(input logic exp, input string tag);
        @(negedge clk);
        check(tag, {31'd0, cpu_irq}, {31'd0, exp});
        @(posedge clk); #1;
    endtask

    task automatic pins(input logic [31:0] v);
        irq_src = v;
        @(posedge clk); #1;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        expect_rd(4'd0, 32'h0, "R1 status");
        expect_rd(4'd2, 32'h0, "R1 enable");
        expect_rd(4'd6, 32'hFFFF_FFFF, "R1 vector");
        expect_rd(4'd7, 32'h0, "R1 master");
        expect_irq(1'b0, "R1 irq");

        // R2 master keeps two bits; R13 SIGNAL mode
        wr(4'd7, 32'hFFFF_FFF0);
        expect_rd(4'd7, 32'h0, "R2 master upper dropped");
        wr(4'd7, 32'hFFFF_FFFD);
        expect_rd(4'd7, 32'h1, "R2 R13 master SIGNAL");

        // R10 software interrupt, R9 R5 R6 R7
        wr(4'd0, 32'h30);
        expect_rd(4'd0, 32'h30, "R10 status write capture off");
        wr(4'd2, 32'h10);
        expect_rd(4'd2, 32'h10, "R9 enable replace");
        expect_rd(4'd1, 32'h10, "R5 pending");
        expect_rd(4'd6, 32'd4, "R6 vector");
        expect_irq(1'b1, "R7 irq high");
        wr(4'd4, 32'h21);
        expect_rd(4'd2, 32'h31, "R9 set-enable");
        wr(4'd5, 32'h10);
        expect_rd(4'd2, 32'h21, "R9 clear-enable");
        expect_rd(4'd1, 32'h20, "R5 pending after clear");
        expect_rd(4'd6, 32'd5, "R6 vector moves");

        // R8 acknowledge
        wr(4'd3, 32'h20);
        expect_rd(4'd0, 32'h10, "R8 ack clears");
        expect_rd(4'd6, 32'hFFFF_FFFF, "R6 vector none");
        expect_irq(1'b0, "R7 irq low");

        // R12 capture off ignores lines
        pins(32'h0001_0001);
        pins(32'h0001_0001);
        expect_rd(4'd0, 32'h10, "R12 lines ignored");
        pins(32'h0);

        // R13 RUN, R10 ignored status write
        wr(4'd7, 32'h3);
        expect_rd(4'd7, 32'h3, "R13 master RUN");
        wr(4'd0, 32'hFFFF);
        expect_rd(4'd0, 32'h10, "R10 status write ignored");

        // R3 level capture, sticky
        pins(32'h4);
        pins(32'h0);
        expect_rd(4'd0, 32'h14, "R3 level sticky");
        wr(4'd4, 32'h4);
        expect_rd(4'd1, 32'h4, "R5 pending level");
        expect_rd(4'd6, 32'd2, "R6 vector level");
        expect_irq(1'b1, "R7 irq level");
        wr(4'd3, 32'h4);
        expect_rd(4'd0, 32'h10, "R8 ack level low");

        // R8 acknowledge while level still high
        pins(32'h8);
        wr(4'd3, 32'h8);
        expect_rd(4'd0, 32'h18, "R8 capture wins over ack");
        pins(32'h0);
        wr(4'd3, 32'h8);
        expect_rd(4'd0, 32'h10, "R8 ack after release");

        // R4 edge capture
        pins(32'h0002_0000);
        expect_rd(4'd0, 32'h0002_0010, "R4 edge sets");
        wr(4'd3, 32'h0002_0000);
        expect_rd(4'd0, 32'h10, "R4 held high no reset");
        pins(32'h0);
        pins(32'h0002_0000);
        pins(32'h0);
        expect_rd(4'd0, 32'h0002_0010, "R4 new edge sticky");

        // R6 priority order
        wr(4'd4, 32'hFFFF_FFFF);
        expect_rd(4'd6, 32'd4, "R6 lowest wins");
        wr(4'd3, 32'h10);
        expect_rd(4'd6, 32'd17, "R6 next line");

        // R7 R13 CAPTURE mode gates output
        wr(4'd7, 32'h2);
        expect_irq(1'b0, "R7 R13 output off");
        expect_rd(4'd1, 32'h0002_0000, "R5 pending kept");

        // R11 write-only and unmapped offsets
        expect_rd(4'd3, 32'h0, "R11 ack reads 0");
        expect_rd(4'd4, 32'h0, "R11 set reads 0");
        expect_rd(4'd5, 32'h0, "R11 clear reads 0");
        expect_rd(4'd9, 32'h0, "R11 unmapped reads 0");
        wr(4'd12, 32'hFFFF_FFFF);
        expect_rd(4'd0, 32'h0002_0000, "R11 unmapped write status");
        expect_rd(4'd2, 32'hFFFF_FFFF, "R11 unmapped write enable");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule